// File: doc/BRIEF.md
# Residue-Domain Multiply-Accumulate Unit

This block runs a multiply-accumulate entirely in residue form. A number is carried as a tuple of small digits, one digit per modulus. The moduli are pairwise coprime. Each lane owns one modulus and computes its own product and running sum modulo that modulus. No carries pass between lanes, so a wide binary multiply-add becomes several narrow, identical lanes. The range of values the tuple can represent is the product M of all the moduli.

Each lane multiplies two 4-bit digits through a 256-entry table. The table has 8 address bits and 4 data bits. The lane then adds the table output to its running digit with a modular adder. The surrounding logic supplies operand digits that are already converted to residue form, and it reads back the accumulated tuple. Conversion to and from binary is outside this block, and so is division.

The control inputs choose the mode:
- A valid beat without accumulate loads the digit-wise product, which serves as a plain multiply.
- A valid beat with accumulate adds the product into the running value.
- A clear empties every lane.

The result is registered, and an output valid follows the input valid one cycle later.

Top module: `rmac_top`

## Requirements
- R1: After reset every accumulator digit is 0 and `out_valid` is 0.
- R2: `out_valid` equals the value `in_valid` had on the previous clock edge.
- R3: Digits are packed four bits per lane, lane i at bits [4i+3:4i], lane 0 holding modulus 3, lane 1 modulus 4 and lane 2 modulus 5 by default. A valid beat with `acc_en` low loads each lane with (a_i*b_i) mod m_i. For example, 8 = (2,0,3) times 2 = (2,2,2) gives (1,0,1), which is 16.
- R4: A valid beat with `acc_en` high and `acc_clear` low sets lane i to (acc_i + a_i*b_i) mod m_i.
- R5: `acc_clear` with `in_valid` low sets every digit to 0 on the next edge.
- R6: `acc_clear` together with `in_valid` and `acc_en` starts a fresh sum, so lane i becomes (a_i*b_i) mod m_i.
- R7: With `in_valid` and `acc_clear` both low the accumulator holds its value, whatever `acc_en` is.
- R8: Every accumulated digit stays below its own modulus.
- R9: An operand digit at or above its modulus, up to 15, is used by its value modulo m_i.
- R10: Over any sequence of beats, lane i equals the integer result kept modulo M and then reduced modulo m_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand tuples are valid this cycle |
| acc_clear | input | 1 | Empty the accumulator |
| acc_en | input | 1 | Add the product to the running value instead of loading it |
| op_a | input | 4*NCH | First operand, one digit per lane |
| op_b | input | 4*NCH | Second operand, one digit per lane |
| out_valid | output | 1 | Accumulator was updated by a valid beat |
| acc_out | output | 4*NCH | Accumulated residue tuple |

## Verification
The assertions check four things on every cycle:
- the valid handshake timing;
- that a clear with no beat zeroes all lanes;
- that idle cycles hold the accumulator;
- that each digit stays below its modulus.

The arithmetic values need the bench's scenarios. These cover the 3,4,5 product example, accumulation chains and restarts through clear, and non-canonical operand digits. A long mixed stream is compared against an integer reference kept modulo M, which exposes any lane whose table or adder has a wrong entry.

// File: rtl/rmac_pkg.sv
package rmac_pkg;
  localparam int DW = 4;
  typedef logic [DW-1:0] digit_t;

  // (a*b) mod m for one lane
  function automatic digit_t mod_mul(input digit_t a, input digit_t b, input int unsigned m);
    int unsigned p;
    p = int'(a) * int'(b);
    return digit_t'(p % m);
  endfunction

  // (a+b) mod m for reduced operands
  function automatic digit_t mod_add(input digit_t a, input digit_t b, input int unsigned m);
    int unsigned s;
    s = int'(a) + int'(b);
    if (s >= m) s = s - m;
    return digit_t'(s);
  endfunction
endpackage

// File: rtl/rmac_mul_lut.sv
module rmac_mul_lut #(
  parameter int unsigned MOD = 3
) (
  input  logic [3:0] a,
  input  logic [3:0] b,
  output logic [3:0] prod
);
  import rmac_pkg::*;
  localparam int ENTRIES = 1 << (2 * DW);

  digit_t tbl [ENTRIES];

  genvar idx;
  generate
    for (idx = 0; idx < ENTRIES; idx++) begin : g_entry
      assign tbl[idx] = mod_mul(digit_t'(idx >> DW), digit_t'(idx % (1 << DW)), MOD);
    end
  endgenerate

  assign prod = tbl[{a, b}];
endmodule

// File: rtl/rmac_add_mod.sv
module rmac_add_mod #(
  parameter int unsigned MOD = 3
) (
  input  logic [3:0] a,
  input  logic [3:0] b,
  output logic [3:0] sum
);
  import rmac_pkg::*;
  assign sum = mod_add(a, b, MOD);
endmodule

// File: rtl/rmac_lane.sv
module rmac_lane #(
  parameter int unsigned MOD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       acc_clear,
  input  logic       acc_en,
  input  logic [3:0] a,
  input  logic [3:0] b,
  output logic [3:0] acc,
  output logic [3:0] prod,
  output logic [3:0] sum
);
  logic [3:0] base;

  rmac_mul_lut #(.MOD(MOD)) u_mul (.a(a), .b(b), .prod(prod));

  // a clear in the same beat restarts from zero
  assign base = acc_clear ? 4'd0 : acc;

  rmac_add_mod #(.MOD(MOD)) u_add (.a(base), .b(prod), .sum(sum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (in_valid) begin
      acc <= acc_en ? sum : prod;
    end else if (acc_clear) begin
      acc <= '0;
    end
  end
endmodule

// File: rtl/rmac_top.sv
module rmac_top #(
  parameter int          NCH = 3,
  parameter int unsigned MODULI [NCH] = '{3, 4, 5}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             acc_clear,
  input  logic             acc_en,
  input  logic [4*NCH-1:0] op_a,
  input  logic [4*NCH-1:0] op_b,
  output logic             out_valid,
  output logic [4*NCH-1:0] acc_out
);
  localparam int W = 4 * NCH;

  logic [W-1:0] lane_prod;
  logic [W-1:0] lane_sum;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_lane
      rmac_lane #(.MOD(MODULI[i])) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .acc_clear(acc_clear),
        .acc_en   (acc_en),
        .a        (op_a[4*i +: 4]),
        .b        (op_b[4*i +: 4]),
        .acc      (acc_out[4*i +: 4]),
        .prod     (lane_prod[4*i +: 4]),
        .sum      (lane_sum[4*i +: 4])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end
endmodule

// File: rtl/rmac_checker.sv
module rmac_checker #(
  parameter int          NCH = 3,
  parameter int unsigned MODULI [NCH] = '{3, 4, 5}
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             acc_clear,
  input logic             out_valid,
  input logic [4*NCH-1:0] acc_out,
  input logic [4*NCH-1:0] lane_prod
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clear && !in_valid) |=> (acc_out == '0));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !acc_clear) |=> $stable(acc_out));

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_chk
      p_digit_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc_out[4*i +: 4]) < int'(MODULI[i]));
      p_prod_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lane_prod[4*i +: 4]) < int'(MODULI[i]));
    end
  endgenerate
endmodule

bind rmac_top rmac_checker #(.NCH(NCH), .MODULI(MODULI)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .acc_clear(acc_clear),
  .out_valid(out_valid),
  .acc_out  (acc_out),
  .lane_prod(lane_prod)
);

// File: tb/test_rmac_top.sv
`timescale 1ns/1ps
module test_rmac_top;
  localparam int NCH = 3;
  localparam int W = 4 * NCH;
  localparam int MODS [NCH] = '{3, 4, 5};
  localparam int BIGM = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic acc_clear = 1'b0;
  logic acc_en = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic out_valid;
  logic [W-1:0] acc_out;

  int checks = 0;
  int errors = 0;
  int ref_acc = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q [$];
  string tag_q [$];

  rmac_top i_rmac_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clear(acc_clear),
    .acc_en(acc_en), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  always #5 clk = ~clk;

  // integer value reduced to the packed residue tuple
  function automatic logic [W-1:0] to_digits(input int v);
    logic [W-1:0] r;
    r = '0;
    for (int k = 0; k < NCH; k++) r[4*k +: 4] = 4'(v % MODS[k]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one valid beat built from integers x, y
  task automatic op(input int x, input int y, input bit clr, input bit en,
                    input bit bump, input string tag);
    logic [W-1:0] da, db;
    for (int k = 0; k < NCH; k++) begin
      int ra = x % MODS[k];
      int rb = y % MODS[k];
      if (bump && ra + MODS[k] <= 15) ra += MODS[k];
      if (bump && rb + MODS[k] <= 15) rb += MODS[k];
      da[4*k +: 4] = 4'(ra);
      db[4*k +: 4] = 4'(rb);
    end
    if (en) ref_acc = ((clr ? 0 : ref_acc) + x * y) % BIGM;
    else    ref_acc = (x * y) % BIGM;
    exp_q.push_back(to_digits(ref_acc));
    tag_q.push_back(tag);
    in_valid = 1'b1; acc_clear = clr; acc_en = en; op_a = da; op_b = db;
    @(negedge clk);
    in_valid = 1'b0; acc_clear = 1'b0; acc_en = 1'b0;
  endtask

  // beat without valid; checks the state directly one cycle later
  task automatic ctrl(input bit clr, input bit en, input string tag);
    if (clr) ref_acc = 0;
    in_valid = 1'b0; acc_clear = clr; acc_en = en;
    op_a = {W{1'b1}}; op_b = {W{1'b1}};
    @(negedge clk);
    acc_clear = 1'b0; acc_en = 1'b0;
    check({tag, " acc"}, acc_out, to_digits(ref_acc));
    check("R2 no valid out", {{(W-1){1'b0}}, out_valid}, '0);
  endtask

  // monitor: compares each registered result with the queued expectation
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: out_valid with nothing expected actual=1 expected=0");
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, acc_out, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset acc", acc_out, '0);
    check("R1 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", acc_out, '0);

    op(8, 2, 1'b0, 1'b0, 1'b0, "R3 product 8*2");
    check("R3 tuple (1,0,1)", acc_out, 12'h101);
    ctrl(1'b1, 1'b0, "R5 clear");

    op(7, 11, 1'b0, 1'b1, 1'b0, "R4 acc step1");
    op(13, 29, 1'b0, 1'b1, 1'b0, "R4 acc step2");
    op(59, 59, 1'b0, 1'b1, 1'b0, "R4 acc step3");
    ctrl(1'b0, 1'b1, "R7 acc_en without valid");
    ctrl(1'b0, 1'b0, "R7 idle hold");
    op(4, 9, 1'b1, 1'b1, 1'b0, "R6 clear with accumulate");
    op(5, 6, 1'b0, 1'b1, 1'b0, "R4 after restart");
    op(8, 2, 1'b0, 1'b0, 1'b1, "R9 non-canonical product");
    op(17, 23, 1'b0, 1'b1, 1'b1, "R9 non-canonical accumulate");
    ctrl(1'b1, 1'b0, "R5 clear again");

    for (int n = 0; n < 60; n++) begin
      int x = $urandom_range(0, BIGM - 1);
      int y = $urandom_range(0, BIGM - 1);
      int sel = $urandom_range(0, 9);
      if (sel == 0)      op(x, y, 1'b0, 1'b0, 1'b0, "R10 stream load");
      else if (sel == 1) op(x, y, 1'b1, 1'b1, 1'b0, "R10 stream restart");
      else if (sel == 2) op(x, y, 1'b0, 1'b1, 1'b1, "R10 stream raw digits");
      else if (sel == 3) ctrl(1'b0, 1'b1, "R7 stream idle");
      else               op(x, y, 1'b0, 1'b1, 1'b0, "R10 stream accumulate");
    end
    @(negedge clk);
    check("R8 final digits", acc_out, to_digits(ref_acc));
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: pending=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule